// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Access Protection

This block sits between a processor and a physically addressed cache. It translates virtual byte addresses into physical ones. Each request carries an access kind: data load, data store or instruction fetch. The block compares the request's virtual page number against every stored entry in the same cycle. A matching entry must also hold a resident page and permit the requested kind of access. The block answers in the same cycle with exactly one of four outcomes:

- a translation,
- a miss,
- a page fault for a swapped-out page,
- a protection fault.

Entries are loaded through a refill port, driven by an external table walker or by software. Loading an entry takes one clock cycle. When every slot is occupied, the least recently used entry is replaced. A flush input empties the whole buffer in one cycle. The block does not walk page tables and does not service faults.

Top module: `tlb_xlate`

## Requirements
- R1: On a translation, `rsp_paddr` is the entry's frame number followed by the low 13 bits of `req_vaddr`, which pass through unchanged (8 Kbyte pages).
- R2: A request matches an entry when the entry is present and its stored page number equals `req_vaddr[31:13]`; a request that matches no present entry reports a miss.
- R3: A matching entry whose resident bit is 0 reports a page fault and no translation, whatever the access kind.
- R4: Access kind codes are 0 load, 1 store, 2 fetch. Permission codes are 0 read-only (load only), 1 read/write (load and store), 2 execute-only (fetch only) and 3 no access. A resident match whose code does not allow the kind reports a protection fault.
- R5: For a valid request, exactly one of `rsp_hit`, `rsp_miss`, `rsp_pgfault`, `rsp_protfault` is high in the same cycle. With `req_valid` low, all four flags are low. `rsp_paddr` is zero unless `rsp_hit` is high.
- R6: A refill writes page number, frame number, resident bit and permission code in one clock edge. The entry answers lookups from the next cycle onward.
- R7: Refill never creates two entries for one page number. If the page number is already present, that entry is overwritten. Otherwise the lowest-index empty slot is used, and failing that the least recently used entry.
- R8: Recency is updated by every refill and every translation hit. Misses, page faults and protection faults leave it unchanged.
- R9: A flush clears every entry's present flag at the clock edge. A refill presented in the same cycle as a flush is discarded.
- R10: After reset every entry is empty, so every request misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_vaddr | input | 32 | Virtual byte address |
| req_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| rsp_hit | output | 1 | Translation produced |
| rsp_miss | output | 1 | No present entry matches |
| rsp_pgfault | output | 1 | Matching entry is swapped out |
| rsp_protfault | output | 1 | Access kind not permitted |
| rsp_paddr | output | 32 | Physical address, zero unless hit |
| fill_en | input | 1 | Refill strobe |
| fill_vpn | input | 19 | Page number to load |
| fill_pfn | input | 19 | Physical frame number to load |
| fill_resident | input | 1 | Page is resident in memory |
| fill_perm | input | 2 | Permission code |
| flush | input | 1 | Clear all entries |

## Verification
The assertions assume that the inputs are known after reset. They also assume that the request kind code 3 never appears. The stimulus only produces codes 0 to 2. The duplicate-free property checks the match vector on every cycle. It holds for any sequence of refills, so the random mix deliberately refills page numbers from a small pool that is already resident. A reference model in the bench mirrors the replacement order. Directed sequences add the recency and same-cycle flush cases on top of it.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

   typedef enum logic [1:0] {
      ACC_LOAD  = 2'd0,
      ACC_STORE = 2'd1,
      ACC_FETCH = 2'd2
   } acc_e;

   typedef enum logic [1:0] {
      PERM_RO   = 2'd0,
      PERM_RW   = 2'd1,
      PERM_XO   = 2'd2,
      PERM_NONE = 2'd3
   } perm_e;

   // Access matrix: which kinds a permission code admits.
   function automatic logic perm_allows(input perm_e p, input acc_e k);
      case (p)
         PERM_RO: perm_allows = (k == ACC_LOAD);
         PERM_RW: perm_allows = (k == ACC_LOAD) || (k == ACC_STORE);
         PERM_XO: perm_allows = (k == ACC_FETCH);
         default: perm_allows = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/tlb_first.sv
module tlb_first #(
   parameter int N = 16,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  vec,
   output logic          any,
   output logic [IW-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) idx = IW'(i);
      end
   end

   assign any = |vec;
endmodule

// File: rtl/tlb_slot.sv
module tlb_slot
   import tlb_pkg::*;
#(
   parameter int VPN_W = 19,
   parameter int PFN_W = 19
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             wr_en,
   input  logic [VPN_W-1:0] wr_vpn,
   input  logic [PFN_W-1:0] wr_pfn,
   input  logic             wr_res,
   input  perm_e            wr_perm,
   input  logic [VPN_W-1:0] look_vpn,
   input  logic [VPN_W-1:0] fill_vpn,
   output logic             present,
   output logic             look_hit,
   output logic             fill_hit,
   output logic [PFN_W-1:0] pfn,
   output logic             resident,
   output perm_e            perm
);
   logic [VPN_W-1:0] tag_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         present  <= 1'b0;
         tag_q    <= '0;
         pfn      <= '0;
         resident <= 1'b0;
         perm     <= PERM_NONE;
      end else if (flush) begin
         present  <= 1'b0;
      end else if (wr_en) begin
         present  <= 1'b1;
         tag_q    <= wr_vpn;
         pfn      <= wr_pfn;
         resident <= wr_res;
         perm     <= wr_perm;
      end
   end

   assign look_hit = present && (tag_q == look_vpn);
   assign fill_hit = present && (tag_q == fill_vpn);

   AST_SLOT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !flush) |=> (present && tag_q == $past(wr_vpn))); // R6

   AST_SLOT_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !present); // R9
endmodule

// File: rtl/tlb_age.sv
module tlb_age #(
   parameter int N = 16,
   localparam int IW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          touch_en,
   input  logic [IW-1:0] touch_idx,
   output logic [IW-1:0] victim
);
   logic [IW-1:0] age [N];
   logic [N-1:0]  oldest;
   logic          unused_any;

   // Ages form a permutation of 0..N-1; the touched entry becomes 0.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) age[i] <= IW'(i);
      end else if (touch_en) begin
         for (int i = 0; i < N; i++) begin
            if (IW'(i) == touch_idx)          age[i] <= '0;
            else if (age[i] < age[touch_idx]) age[i] <= age[i] + 1'b1;
         end
      end
   end

   for (genvar g = 0; g < N; g++) begin : g_old
      assign oldest[g] = (age[g] == IW'(N - 1));
   end

   tlb_first #(.N(N)) u_pick (.vec(oldest), .any(unused_any), .idx(victim));

   AST_AGE_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(oldest)); // R8
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
   import tlb_pkg::*;
#(
   parameter int VA_W      = 32,
   parameter int PA_W      = 32,
   parameter int PAGE_BITS = 13,
   parameter int ENTRIES   = 16,
   localparam int VPN_W    = VA_W - PAGE_BITS,
   localparam int PFN_W    = PA_W - PAGE_BITS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [VA_W-1:0]  req_vaddr,
   input  logic [1:0]       req_kind,
   output logic             rsp_hit,
   output logic             rsp_miss,
   output logic             rsp_pgfault,
   output logic             rsp_protfault,
   output logic [PA_W-1:0]  rsp_paddr,
   input  logic             fill_en,
   input  logic [VPN_W-1:0] fill_vpn,
   input  logic [PFN_W-1:0] fill_pfn,
   input  logic             fill_resident,
   input  logic [1:0]       fill_perm,
   input  logic             flush
);
   localparam int IW = $clog2(ENTRIES);

   if (PAGE_BITS < 1 || PAGE_BITS >= VA_W || PAGE_BITS >= PA_W) begin : g_bad_page
      $error("page offset width must be below both address widths");
   end
   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_depth
      $error("entry count must be a power of two of at least 2");
   end

   logic [VPN_W-1:0] look_vpn;
   logic [ENTRIES-1:0] present, look_vec, fill_vec;
   logic [PFN_W-1:0] pfn_a [ENTRIES];
   logic [ENTRIES-1:0] res_a;
   perm_e perm_a [ENTRIES];

   logic          look_any, fill_any, empty_any, fill_go, touch_en;
   logic [IW-1:0] look_idx, fill_idx, empty_idx, lru_idx, victim_idx, touch_idx;
   logic          sel_allow;

   assign look_vpn = req_vaddr[VA_W-1:PAGE_BITS];
   assign fill_go  = fill_en && !flush;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      tlb_slot #(.VPN_W(VPN_W), .PFN_W(PFN_W)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .flush    (flush),
         .wr_en    (fill_go && (victim_idx == IW'(g))),
         .wr_vpn   (fill_vpn),
         .wr_pfn   (fill_pfn),
         .wr_res   (fill_resident),
         .wr_perm  (perm_e'(fill_perm)),
         .look_vpn (look_vpn),
         .fill_vpn (fill_vpn),
         .present  (present[g]),
         .look_hit (look_vec[g]),
         .fill_hit (fill_vec[g]),
         .pfn      (pfn_a[g]),
         .resident (res_a[g]),
         .perm     (perm_a[g])
      );
   end

   tlb_first #(.N(ENTRIES)) u_look  (.vec(look_vec), .any(look_any),  .idx(look_idx));
   tlb_first #(.N(ENTRIES)) u_fill  (.vec(fill_vec), .any(fill_any),  .idx(fill_idx));
   tlb_first #(.N(ENTRIES)) u_empty (.vec(~present), .any(empty_any), .idx(empty_idx));

   tlb_age #(.N(ENTRIES)) u_age (
      .clk       (clk),
      .rst_n     (rst_n),
      .touch_en  (touch_en),
      .touch_idx (touch_idx),
      .victim    (lru_idx)
   );

   // Victim order: same page already held, then lowest empty, then LRU.
   always_comb begin
      if (fill_any)       victim_idx = fill_idx;
      else if (empty_any) victim_idx = empty_idx;
      else                victim_idx = lru_idx;
   end

   assign sel_allow = perm_allows(perm_a[look_idx], acc_e'(req_kind));

   always_comb begin
      rsp_hit       = 1'b0;
      rsp_miss      = 1'b0;
      rsp_pgfault   = 1'b0;
      rsp_protfault = 1'b0;
      rsp_paddr     = '0;
      if (req_valid) begin
         if (!look_any)             rsp_miss      = 1'b1;
         else if (!res_a[look_idx]) rsp_pgfault   = 1'b1;
         else if (!sel_allow)       rsp_protfault = 1'b1;
         else begin
            rsp_hit   = 1'b1;
            rsp_paddr = {pfn_a[look_idx], req_vaddr[PAGE_BITS-1:0]};
         end
      end
   end

   assign touch_en  = fill_go || rsp_hit;
   assign touch_idx = fill_go ? victim_idx : look_idx;

   AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> $countones({rsp_hit, rsp_miss, rsp_pgfault, rsp_protfault}) == 1); // R5
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> !(rsp_hit || rsp_miss || rsp_pgfault || rsp_protfault)); // R5
   AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> rsp_paddr[PAGE_BITS-1:0] == req_vaddr[PAGE_BITS-1:0]); // R1
   AST_NO_DUP: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(look_vec)); // R7
   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (!req_valid || rsp_miss)); // R9
   AST_STORE_NEEDS_RW: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_hit && req_kind == 2'd1) |-> perm_a[look_idx] == PERM_RW); // R4
endmodule

// File: tb/sim_tlb_xlate.sv
module sim_tlb_xlate;
   localparam int N  = 16;
   localparam int LD = 0, ST = 1, FE = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, fill_en = 1'b0, fill_resident = 1'b0, flush = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic [1:0]  req_kind = '0, fill_perm = '0;
   logic [18:0] fill_vpn = '0, fill_pfn = '0;
   logic rsp_hit, rsp_miss, rsp_pgfault, rsp_protfault;
   logic [31:0] rsp_paddr;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   tlb_xlate u0 (.*);

   // Reference model state
   logic [18:0] m_vpn [N];
   logic [18:0] m_pfn [N];
   bit          m_pres [N];
   bit          m_res [N];
   logic [1:0]  m_perm [N];
   int          m_age [N];

   function automatic int m_find(input logic [18:0] v);
      for (int i = 0; i < N; i++) if (m_pres[i] && m_vpn[i] == v) return i;
      return -1;
   endfunction

   function automatic bit m_allow(input logic [1:0] p, input logic [1:0] k);
      case (p)
         2'd0: return k == 2'd0;
         2'd1: return k == 2'd0 || k == 2'd1;
         2'd2: return k == 2'd2;
         default: return 1'b0;
      endcase
   endfunction

   task automatic m_touch(input int t);
      int old = m_age[t];
      for (int j = 0; j < N; j++) if (m_age[j] < old) m_age[j]++;
      m_age[t] = 0;
   endtask

   task automatic chk(input bit ok, input string tag, input logic [35:0] got, input logic [35:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // One clock cycle: drive at falling edge, sample before rising edge.
   task automatic cyc(input bit rv, input logic [31:0] va, input int kind,
                      input bit fe, input logic [18:0] fv, input logic [18:0] fp,
                      input bit fr, input logic [1:0] fpm, input bit fl, input string tag,
                      output logic [3:0] obs, output logic [31:0] pa);
      logic [3:0]  e;
      logic [31:0] epa;
      int hi, w;
      req_valid = rv; req_vaddr = va; req_kind = 2'(kind);
      fill_en = fe; fill_vpn = fv; fill_pfn = fp; fill_resident = fr; fill_perm = fpm;
      flush = fl;
      #3;
      obs = {rsp_hit, rsp_miss, rsp_pgfault, rsp_protfault};
      pa  = rsp_paddr;
      e = 4'b0000; epa = '0; hi = -1;
      if (rv) begin
         hi = m_find(va[31:13]);
         if (hi < 0)                          e = 4'b0100;
         else if (!m_res[hi])                 e = 4'b0010;
         else if (!m_allow(m_perm[hi], 2'(kind))) e = 4'b0001;
         else begin e = 4'b1000; epa = {m_pfn[hi], va[12:0]}; end
      end
      chk(obs == e && pa == epa, tag, {obs, pa}, {e, epa});
      @(posedge clk);
      if (fl) begin
         for (int i = 0; i < N; i++) m_pres[i] = 1'b0;
      end else if (fe) begin
         w = m_find(fv);
         if (w < 0) for (int i = N - 1; i >= 0; i--) if (!m_pres[i]) w = i;
         if (w < 0) for (int i = 0; i < N; i++) if (m_age[i] == N - 1) w = i;
         m_vpn[w] = fv; m_pfn[w] = fp; m_res[w] = fr; m_perm[w] = fpm; m_pres[w] = 1'b1;
         m_touch(w);
      end else if (e == 4'b1000) begin
         m_touch(hi);
      end
      @(negedge clk);
   endtask

   task automatic fill(input logic [18:0] v, input logic [18:0] p, input bit r, input logic [1:0] pm);
      logic [3:0] o; logic [31:0] a;
      cyc(0, '0, LD, 1, v, p, r, pm, 0, "R6 refill", o, a);
   endtask

   task automatic look(input logic [31:0] va, input int k, input string tag,
                       output logic [3:0] o, output logic [31:0] a);
      cyc(1, va, k, 0, '0, '0, 0, 2'd0, 0, tag, o, a);
   endtask

   task automatic do_flush();
      logic [3:0] o; logic [31:0] a;
      cyc(0, '0, LD, 0, '0, '0, 0, 2'd0, 1, "R9 flush", o, a);
   endtask

   initial begin
      logic [3:0] o; logic [31:0] a;
      for (int i = 0; i < N; i++) begin
         m_pres[i] = 0; m_res[i] = 0; m_age[i] = i; m_vpn[i] = '0; m_pfn[i] = '0; m_perm[i] = 2'd3;
      end
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R10: empty after reset
      look(32'h1234_5678, LD, "R10 reset miss", o, a);
      chk(o == 4'b0100 && a == 0, "R10", {o, a}, {4'b0100, 32'h0});
      // R5: idle request raises nothing
      cyc(0, 32'hFFFF_FFFF, ST, 0, '0, '0, 0, 2'd0, 0, "R5 idle", o, a);

      // R1/R2/R6: load then translate next cycle
      fill(19'h0_ABCD, 19'h5_4321, 1, 2'd1);
      look({19'h0_ABCD, 13'h1F0F}, LD, "R1 translate", o, a);
      chk(o == 4'b1000 && a == {19'h5_4321, 13'h1F0F}, "R1", {o, a}, {4'b1000, 19'h5_4321, 13'h1F0F});
      look({19'h0_ABCE, 13'h0}, LD, "R2 neighbour page", o, a);
      chk(o == 4'b0100, "R2", {o, a}, {4'b0100, 32'h0});

      // R3: swapped-out page
      fill(19'h1_1111, 19'h0_0007, 0, 2'd1);
      look({19'h1_1111, 13'h0040}, FE, "R3 page fault", o, a);
      chk(o == 4'b0010 && a == 0, "R3", {o, a}, {4'b0010, 32'h0});

      // R4: permission matrix
      for (int p = 0; p < 4; p++) fill(19'h2_0000 + 19'(p), 19'h3_0000 + 19'(p), 1, 2'(p));
      for (int p = 0; p < 4; p++) begin
         for (int k = 0; k < 3; k++) begin
            logic [3:0] ex;
            ex = ((p == 0 && k == LD) || (p == 1 && k != FE) || (p == 2 && k == FE)) ? 4'b1000 : 4'b0001;
            look({19'h2_0000 + 19'(p), 13'h0}, k, "R4 permission", o, a);
            chk(o == ex, "R4", {o, a}, {ex, 32'h0});
         end
      end

      // R9: flush, and a refill in the flush cycle is dropped
      do_flush();
      look({19'h0_ABCD, 13'h0}, LD, "R9 after flush", o, a);
      chk(o == 4'b0100, "R9", {o, a}, {4'b0100, 32'h0});
      cyc(0, '0, LD, 1, 19'h4_4444, 19'h1, 1, 2'd1, 1, "R9 flush+fill", o, a);
      look({19'h4_4444, 13'h0}, LD, "R9 dropped refill", o, a);
      chk(o == 4'b0100, "R9", {o, a}, {4'b0100, 32'h0});

      // R7: refilling a held page overwrites it; no slot lost to a duplicate
      fill(19'h5_0000, 19'h0_0111, 1, 2'd1);
      fill(19'h5_0000, 19'h0_0222, 1, 2'd1);
      for (int i = 1; i < N; i++) fill(19'h5_0000 + 19'(i), 19'h6_0000 + 19'(i), 1, 2'd1);
      look({19'h5_0000, 13'h0}, LD, "R7 newest frame", o, a);
      chk(o == 4'b1000 && a == {19'h0_0222, 13'h0}, "R7", {o, a}, {4'b1000, 19'h0_0222, 13'h0});
      for (int i = 1; i < N; i++) begin
         look({19'h5_0000 + 19'(i), 13'h0}, LD, "R7 all retained", o, a);
         chk(o == 4'b1000, "R7", {o, a}, {4'b1000, 32'h0});
      end

      // R8: LRU, hits refresh, faults do not
      do_flush();
      for (int i = 0; i < N; i++) fill(19'h7_0000 + 19'(i), 19'(i), 1, 2'd0);
      look({19'h7_0000, 13'h0}, LD, "R8 refresh oldest", o, a);
      fill(19'h7_1000, 19'h9, 1, 2'd0);
      look({19'h7_0001, 13'h0}, LD, "R8 evicted LRU", o, a);
      chk(o == 4'b0100, "R8", {o, a}, {4'b0100, 32'h0});
      look({19'h7_0000, 13'h0}, LD, "R8 refreshed kept", o, a);
      chk(o == 4'b1000, "R8", {o, a}, {4'b1000, 32'h0});
      look({19'h7_0002, 13'h0}, ST, "R8 fault no refresh", o, a);
      chk(o == 4'b0001, "R4", {o, a}, {4'b0001, 32'h0});
      fill(19'h7_1001, 19'hA, 1, 2'd0);
      look({19'h7_0002, 13'h0}, LD, "R8 faulted page evicted", o, a);
      chk(o == 4'b0100, "R8", {o, a}, {4'b0100, 32'h0});

      // Random mix against the model: R2 R3 R4 R5 R6 R7 R8 R9
      for (int n = 0; n < 4000; n++) begin
         int r = int'($urandom_range(0, 99));
         logic [18:0] v = 19'h3_0000 + 19'($urandom_range(0, 23) * 3);
         logic [31:0] va = {v, 13'($urandom)};
         if (r < 60)
            cyc(1, va, int'($urandom_range(0, 2)), 0, '0, '0, 0, 2'd0, 0, "R2 R4 random lookup", o, a);
         else if (r < 88)
            cyc(r < 75, va, int'($urandom_range(0, 2)), 1, v, 19'($urandom),
                $urandom_range(0, 9) != 0, 2'($urandom), 0, "R7 random refill", o, a);
         else if (r < 90)
            cyc(0, va, LD, r == 89, v, 19'($urandom), 1, 2'd1, 1, "R9 random flush", o, a);
         else
            cyc(0, va, int'($urandom_range(0, 2)), 0, '0, '0, 0, 2'd0, 0, "R5 random idle", o, a);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(1_500_000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got hang expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule